// File: doc/BRIEF.md
# Slow-to-Fast Page Promotion Decider

This unit sits beside the memory management logic of a system that has two off-chip memories: a small fast region and a large slow region. It does not move any data. It watches the stream of page accesses, keeps a small saturating access counter for every page, and decides when a page that lives in the slow region has become busy enough to be copied back into the fast region. When that happens it issues a promotion request that names the page.

The decision compares the counter of the slow page that was just touched with the mean counter value of all pages that are currently fast. That mean is scaled by a programmable threshold in unsigned 4.4 fixed point. Division is avoided by comparing `count × 16 × fast_pages` against `threshold × fast_sum`. A threshold of zero makes every counted touch of a slow page a promotion, so the fast region behaves like a cache. The all-ones code disables promotion, which leaves a pure spill policy. A write-only mode counts and judges writes only.

The page mover reports each completed relocation on the move inputs. The unit uses these reports to keep its own map of which pages are fast, and it resets the counter of the page that moved. Access events come in on a valid/ready stream. The unit refuses an event (`acc_ready` low) while a move report is present, or while an earlier promotion request is still waiting for `req_ready`. Promotion requests leave on a valid/ready stream and are held unchanged until they are taken.

Top module: `page_promote_top`

## Requirements
- R1: After reset no request is pending, `acc_ready` is high, all counters are zero, and the pages numbered below `INIT_FAST` are in the fast region.
- R2: An access to a fast page never raises a request. When that access is counted, it raises the page's counter and so the fast-region mean.
- R3: A counted access to a slow page with threshold T other than 0 and 0xFF raises a request exactly when C×16×N > T×S. Here C is the page's counter after the access, N is the number of fast pages and S is the sum of their counters. The right side is zero when there are no fast pages.
- R4: With T = 0x00, every counted access to a slow page raises a request.
- R5: With T = 0xFF, no access ever raises a request.
- R6: A move report to the slow region (`mv_to_fast` = 0) resets the page's counter, marks the page slow, and removes its counter from S and the page from N.
- R7: A move report to the fast region (`mv_to_fast` = 1) resets the page's counter and marks the page fast. Its counter, now zero, joins S, and N grows by one.
- R8: With `wr_only` = 1, only accesses with `acc_write` = 1 are counted or judged. Reads have no effect on any counter and never raise a request.
- R9: Counters saturate at 2^CNT_W − 1 and never wrap.
- R10: A pending request holds `req_valid` and `req_page` stable until `req_ready` is high. `acc_ready` is low while a request is pending and not being taken, and while `mv_valid` is high.
- R11: A request appears on `req_valid`/`req_page` in the cycle after the access that caused it is accepted, and it carries that access's page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr | input | 8 | Promotion threshold, unsigned 4.4; 0xFF means infinite |
| wr_only | input | 1 | Count and judge writes only |
| acc_valid | input | 1 | Access event valid |
| acc_ready | output | 1 | Access event accepted this cycle |
| acc_page | input | PG_W | Accessed page number |
| acc_write | input | 1 | Access is a write |
| mv_valid | input | 1 | A page has been relocated |
| mv_page | input | PG_W | Relocated page number |
| mv_to_fast | input | 1 | Relocation destination: 1 fast, 0 slow |
| req_valid | output | 1 | Promotion request valid |
| req_ready | input | 1 | Promotion request taken |
| req_page | output | PG_W | Page to promote |

## Verification
The bench sweeps both counting modes across a set of thresholds: zero, the infinite code, and several finite ratios placed so that the inequality flips at different counter values. A strict-versus-non-strict comparison error, or a mean taken over the wrong set of pages, then shows up as a request one access early or late. A slow page is driven past the counter maximum, so a wrapping counter would fall to zero and stop requesting where a saturating one keeps requesting. Pages are demoted and promoted in the middle of a run. A design that kept a demoted page's history, or left its counter in the fast sum, would give different decisions on the following accesses. A stall test holds `req_ready` low with a second access waiting, which exposes a request that changes or drops while blocked, or an access that is accepted too early.

// File: rtl/page_promote_pkg.sv
package page_promote_pkg;
  localparam int THR_W    = 8;
  localparam int THR_FRAC = 4;
  localparam logic [THR_W-1:0] THR_INF  = '1;
  localparam logic [THR_W-1:0] THR_ZERO = '0;
endpackage

// File: rtl/page_cnt_bank.sv
module page_cnt_bank #(
  parameter int PAGES     = 8,
  parameter int CNT_W     = 4,
  parameter int INIT_FAST = 4,
  localparam int PG_W  = $clog2(PAGES),
  localparam int FC_W  = $clog2(PAGES + 1),
  localparam int SUM_W = CNT_W + FC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [PG_W-1:0]  inc_page,
  input  logic             mv_en,
  input  logic [PG_W-1:0]  mv_page,
  input  logic             mv_to_fast,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             rd_fast,
  output logic [SUM_W-1:0] fast_sum,
  output logic [FC_W-1:0]  fast_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_w [PAGES];
  logic [PAGES-1:0] fast_w;

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    logic [CNT_W-1:0] cnt_q;
    logic             fast_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        fast_q <= (g < INIT_FAST);
      end else if (mv_en && mv_page == PG_W'(g)) begin
        cnt_q  <= '0;
        fast_q <= mv_to_fast;
      end else if (inc_en && inc_page == PG_W'(g) && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
    assign cnt_w[g]  = cnt_q;
    assign fast_w[g] = fast_q;

    // R9: a saturated counter keeps its maximum on a further count
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !mv_en && inc_page == PG_W'(g) && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
    // R6/R7: a move clears the page's counter
    p_mv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_en && mv_page == PG_W'(g)) |=> cnt_q == '0);
  end

  assign rd_cnt  = cnt_w[inc_page];
  assign rd_fast = fast_w[inc_page];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_sum <= '0;
      fast_cnt <= FC_W'(INIT_FAST);
    end else if (mv_en) begin
      if (fast_w[mv_page]) fast_sum <= fast_sum - SUM_W'(cnt_w[mv_page]);
      if (mv_to_fast && !fast_w[mv_page])      fast_cnt <= fast_cnt + 1'b1;
      else if (!mv_to_fast && fast_w[mv_page]) fast_cnt <= fast_cnt - 1'b1;
    end else if (inc_en && fast_w[inc_page] && cnt_w[inc_page] != CNT_MAX) begin
      fast_sum <= fast_sum + 1'b1;
    end
  end

  // R6/R7: the fast-page tally stays within the page count
  p_fcnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fast_cnt <= FC_W'(PAGES));
  // R2: the fast sum never exceeds what the fast counters can hold
  p_sum_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fast_sum <= SUM_W'(fast_cnt) * SUM_W'(CNT_MAX));
endmodule

// File: rtl/promote_cmp.sv
module promote_cmp
  import page_promote_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int FC_W  = 4,
  parameter int SUM_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [FC_W-1:0]  n_fast,
  input  logic [SUM_W-1:0] sum,
  input  logic [THR_W-1:0] thr,
  output logic             promote
);
  localparam int CMP_W = SUM_W + THR_W + 1;
  logic [CMP_W-1:0] lhs, rhs;

  always_comb begin
    lhs = (CMP_W'(cnt) * CMP_W'(n_fast)) << THR_FRAC;
    rhs = CMP_W'(thr) * CMP_W'(sum);
    if (thr == THR_INF)       promote = 1'b0;
    else if (thr == THR_ZERO) promote = 1'b1;
    else                      promote = lhs > rhs;
  end
endmodule

// File: rtl/page_promote_top.sv
module page_promote_top
  import page_promote_pkg::*;
#(
  parameter int PAGES     = 8,
  parameter int CNT_W     = 4,
  parameter int INIT_FAST = 4,
  localparam int PG_W  = $clog2(PAGES),
  localparam int FC_W  = $clog2(PAGES + 1),
  localparam int SUM_W = CNT_W + FC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] thr,
  input  logic             wr_only,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [PG_W-1:0]  acc_page,
  input  logic             acc_write,
  input  logic             mv_valid,
  input  logic [PG_W-1:0]  mv_page,
  input  logic             mv_to_fast,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [PG_W-1:0]  req_page
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             accept, counted, inc_en, rd_fast, promote;
  logic [CNT_W-1:0] rd_cnt, next_cnt;
  logic [SUM_W-1:0] fast_sum;
  logic [FC_W-1:0]  fast_cnt;

  assign acc_ready = (!req_valid || req_ready) && !mv_valid;
  assign accept    = acc_valid && acc_ready;
  assign counted   = !wr_only || acc_write;
  assign inc_en    = accept && counted;
  assign next_cnt  = (rd_cnt == CNT_MAX) ? CNT_MAX : rd_cnt + 1'b1;

  page_cnt_bank #(.PAGES(PAGES), .CNT_W(CNT_W), .INIT_FAST(INIT_FAST)) i_bank (
    .clk(clk), .rst_n(rst_n),
    .inc_en(inc_en), .inc_page(acc_page),
    .mv_en(mv_valid), .mv_page(mv_page), .mv_to_fast(mv_to_fast),
    .rd_cnt(rd_cnt), .rd_fast(rd_fast),
    .fast_sum(fast_sum), .fast_cnt(fast_cnt)
  );

  promote_cmp #(.CNT_W(CNT_W), .FC_W(FC_W), .SUM_W(SUM_W)) i_cmp (
    .cnt(next_cnt), .n_fast(fast_cnt), .sum(fast_sum), .thr(thr), .promote(promote)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_page  <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (inc_en && !rd_fast && promote) begin
        req_valid <= 1'b1;
        req_page  <= acc_page;
      end
    end
  end

  // R10: a blocked request holds its value
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_page)));
  // R10: no access is taken during a move report
  p_mv_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> !acc_ready);
  // R5: infinite threshold never yields a request
  p_inf_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && thr == THR_INF) |=> !req_valid);
  // R4 / R11: zero threshold promotes the touched slow page next cycle
  p_zero_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !rd_fast && thr == THR_ZERO) |=> (req_valid && req_page == $past(acc_page)));
  // R2: fast-page access never requests
  p_fast_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rd_fast) |=> !req_valid);
  // R8: reads in write-only mode never request
  p_rd_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_only && !acc_write) |=> !req_valid);
endmodule

// File: tb/test_page_promote_top.sv
module test_page_promote_top;
  localparam int PAGES = 8, CNT_W = 4, INIT_FAST = 4, PG_W = 3;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic [7:0] thr = 0;
  logic wr_only = 0, acc_valid = 0, acc_write = 0, mv_valid = 0, mv_to_fast = 0, req_ready = 1;
  logic [PG_W-1:0] acc_page = 0, mv_page = 0;
  logic acc_ready, req_valid;
  logic [PG_W-1:0] req_page;

  int n_chk = 0, n_err = 0;
  int m_cnt [PAGES];
  bit m_fast [PAGES];

  always #5 clk = ~clk;

  page_promote_top #(.PAGES(PAGES), .CNT_W(CNT_W), .INIT_FAST(INIT_FAST)) i_page_promote_top (
    .clk(clk), .rst_n(rst_n), .thr(thr), .wr_only(wr_only),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_page(acc_page), .acc_write(acc_write),
    .mv_valid(mv_valid), .mv_page(mv_page), .mv_to_fast(mv_to_fast),
    .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 0; acc_valid = 0; mv_valid = 0; req_ready = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < PAGES; i++) begin m_cnt[i] = 0; m_fast[i] = (i < INIT_FAST); end
    #1;
    chk("R1 req_valid", req_valid, 0);
    chk("R1 acc_ready", acc_ready, 1);
  endtask

  function automatic bit model_decide(int c);
    int n = 0, s = 0;
    for (int i = 0; i < PAGES; i++) if (m_fast[i]) begin n++; s += m_cnt[i]; end
    if (thr == 8'hFF) return 0;
    if (thr == 8'h00) return 1;
    return (c * n * 16) > (int'(thr) * s);
  endfunction

  task automatic access(input int pg, input bit wr);
    bit exp = 0;
    bit cnt_it = !wr_only || wr;
    @(negedge clk);
    acc_valid = 1; acc_page = pg[PG_W-1:0]; acc_write = wr;
    @(negedge clk);
    acc_valid = 0;
    if (cnt_it) begin
      if (m_cnt[pg] < CMAX) m_cnt[pg]++;
      if (!m_fast[pg]) exp = model_decide(m_cnt[pg]);
    end
    if (m_fast[pg]) chk("R2 fast access", req_valid, 0);
    else if (!cnt_it) chk("R8 read ignored", req_valid, 0);
    else if (thr == 8'hFF) chk("R5 infinite", req_valid, 0);
    else if (thr == 8'h00) chk("R4 zero thr", req_valid, 1);
    else if (m_cnt[pg] == CMAX) chk("R9 saturated decision", req_valid, exp);
    else chk("R3 decision", req_valid, exp);
    if (exp && req_valid) chk("R11 req_page", req_page, pg);
  endtask

  task automatic move(input int pg, input bit to_fast);
    @(negedge clk);
    mv_valid = 1; mv_page = pg[PG_W-1:0]; mv_to_fast = to_fast;
    #1 chk("R10 stall on move", acc_ready, 0);
    @(negedge clk);
    mv_valid = 0;
    m_cnt[pg] = 0; m_fast[pg] = to_fast;
    if (to_fast) chk("R7 move done", req_valid, 0);
    else chk("R6 move done", req_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    automatic int thr_list[8] = '{0, 1, 8, 16, 24, 40, 240, 255};
    for (int md = 0; md < 2; md++) begin
      for (int ti = 0; ti < 8; ti++) begin
        wr_only = md[0]; thr = thr_list[ti][7:0];
        do_reset();
        access(0, 1); access(0, 1); access(0, 0);
        access(1, 0); access(1, 1); access(2, 1);
        for (int k = 0; k < 20; k++) access(5, (k % 3) != 0);
        access(6, 1); access(6, 0); access(6, 1);
        move(1, 0);
        for (int k = 0; k < 4; k++) access(1, 1);
        move(5, 1);
        access(5, 1); access(5, 1);
        for (int k = 0; k < 3; k++) access(6, 1);
        move(0, 0); move(2, 0); move(3, 0); move(5, 0);
        access(7, 1);
      end
    end
    // R10 back-pressure with a second access waiting
    wr_only = 0; thr = 0;
    do_reset();
    req_ready = 0;
    access(6, 1);
    acc_valid = 1; acc_page = 3'd7; acc_write = 1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R10 hold valid", req_valid, 1);
      chk("R10 hold page", req_page, 6);
      chk("R10 acc blocked", acc_ready, 0);
      @(negedge clk);
    end
    req_ready = 1;
    @(negedge clk);
    acc_valid = 0;
    chk("R10 next request", req_valid, 1);
    chk("R11 next page", req_page, 7);
    @(negedge clk);
    chk("R10 taken", req_valid, 0);
    summary();
  end
endmodule